// File: doc/BRIEF.md
# Line-D ADD/ADDX Opcode Predecoder

The block looks at one 16-bit opcode word of a 68000-class instruction stream whose top nibble selects the ADD family. It works out whether the word is an ADDX or a plain ADD and at which size. It also produces the two operand addressing modes with their register numbers, and a flag for combinations the operation does not allow. Results appear one clock after a valid strobe and stay put until the next strobe.

A select input lets the same validator screen the single effective-address operand of an NBCD or the destination of an ADDI. In that case the low six opcode bits are interpreted as the effective-address field.

Operand fetch beyond the opcode word, address arithmetic, the address-register add forms and execution belong to other stages.

Top module: `addpd_top`

## Requirements
- R1: While rst_ni is low, and until the first accepted word, valid_o, illegal_o and unhandled_o are 0, and op_o, size_o, both modes and both register outputs are 0.
- R2: A word presented with valid_i high produces valid_o high on the next rising edge, with all results for it. valid_o is low after a cycle without valid_i, and the other outputs hold their values until the next accepted word.
- R3: With sel_i = 0, an opcode 0xD with bit 8 = 1, bits [5:4] = 00 and bits [7:6] not 11 is ADDX (op_o = 2). This test takes priority over the ADD decode. size_o is bits [7:6] (0 byte, 1 word, 2 long). dst_reg_o is bits [11:9] and src_reg_o is bits [2:0].
- R4: For ADDX, both mode outputs are predecrement (code 4) when bit 3 is 1, and data-register direct (code 0) when bit 3 is 0. illegal_o is 0.
- R5: Any other 0xD opcode with bits [7:6] not 11 is ADD (op_o = 1), with size_o taken from bits [7:6]. The effective address is bits [5:3] mode and bits [2:0] register. With bit 8 = 0, the effective address is the source and Dn (bits [11:9], mode 0) is the destination. With bit 8 = 1 the two roles swap.
- R6: Mode codes 0..6 are reported unchanged. Mode 7 uses the register field: 0 gives 7 (absolute short), 1 gives 8 (absolute long), 2 gives 9 (PC plus displacement), 3 gives 10 (PC plus index) and 4 gives 11 (immediate).
- R7: Mode 7 with register 5, 6 or 7 decodes to mode 15 (none), and the word is flagged illegal.
- R8: An ADD source in address-register direct (code 1) is illegal at byte size and legal at word and long size.
- R9: An ADD destination in mode 9, 10, 11 or 15 is illegal.
- R10: With sel_i = 0, an opcode whose top nibble is not 0xD, or an ADD-family word with bits [7:6] = 11 that is not ADDX, gives op_o = 0, unhandled_o = 1 and illegal_o = 0. All other fields are 0.
- R11: With sel_i = 1 (NBCD check), op_o = 3 and size_o = 0. The effective address goes on dst_mode_o/dst_reg_o, with src_mode_o = 15 and src_reg_o = 0. The word is illegal when that mode is 1, 9, 10, 11 or 15.
- R12: With sel_i = 2 (ADDI check), outputs are formed as in R11 but with op_o = 4, and the same set of destination modes is illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Opcode word strobe |
| sel_i | input | 2 | 0 line-D decode, 1 NBCD check, 2 ADDI check, 3 as 0 |
| opcode_i | input | 16 | Opcode word |
| valid_o | output | 1 | Result strobe, one cycle after valid_i |
| op_o | output | 3 | 0 none, 1 ADD, 2 ADDX, 3 NBCD, 4 ADDI |
| size_o | output | 2 | 0 byte, 1 word, 2 long |
| src_mode_o | output | 4 | Source addressing mode code |
| src_reg_o | output | 3 | Source register number |
| dst_mode_o | output | 4 | Destination addressing mode code |
| dst_reg_o | output | 3 | Destination register number |
| illegal_o | output | 1 | Mode combination not permitted |
| unhandled_o | output | 1 | Word is outside this decoder's set |

## Verification
The assertions assume that sel_i and opcode_i are settled whenever valid_i is high at a rising edge. Their values on other cycles are free, and the hold property relies on that freedom. The stimulus drives inputs only at falling edges. While valid_i is low it scrambles opcode_i and sel_i, so any leak into the held outputs shows up. It covers every 0xD word, every six-bit effective address under both check selects, and a few words outside the family, so each mode-7 register code and each size and direction combination is reached.

// File: rtl/addpd_pkg.sv
package addpd_pkg;
  localparam int OPC_W  = 16;
  localparam int REG_W  = 3;
  localparam int MODE_W = 4;

  typedef enum logic [MODE_W-1:0] {
    EA_DN       = 4'd0,
    EA_AN       = 4'd1,
    EA_IND      = 4'd2,
    EA_POSTINC  = 4'd3,
    EA_PREDEC   = 4'd4,
    EA_DISP     = 4'd5,
    EA_INDEX    = 4'd6,
    EA_ABS_W    = 4'd7,
    EA_ABS_L    = 4'd8,
    EA_PC_DISP  = 4'd9,
    EA_PC_INDEX = 4'd10,
    EA_IMM      = 4'd11,
    EA_NONE     = 4'd15
  } ea_mode_e;

  typedef enum logic [2:0] {
    OP_NONE = 3'd0,
    OP_ADD  = 3'd1,
    OP_ADDX = 3'd2,
    OP_NBCD = 3'd3,
    OP_ADDI = 3'd4
  } op_e;

  typedef enum logic [1:0] {
    SZ_B = 2'd0,
    SZ_W = 2'd1,
    SZ_L = 2'd2,
    SZ_X = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    SEL_LINE = 2'd0,
    SEL_NBCD = 2'd1,
    SEL_ADDI = 2'd2,
    SEL_RSVD = 2'd3
  } sel_e;

  typedef struct packed {
    op_e              op;
    size_e            size;
    ea_mode_e         src_mode;
    logic [REG_W-1:0] src_reg;
    ea_mode_e         dst_mode;
    logic [REG_W-1:0] dst_reg;
    logic             unhandled;
  } dec_t;
endpackage

// File: rtl/addpd_ea_decode.sv
module addpd_ea_decode
  import addpd_pkg::*;
(
  input  logic [2:0]       mode_i,
  input  logic [REG_W-1:0] reg_i,
  output ea_mode_e         ea_o
);
  always_comb begin
    if (mode_i != 3'd7) begin
      ea_o = ea_mode_e'({1'b0, mode_i});
    end else begin
      case (reg_i)
        3'd0:    ea_o = EA_ABS_W;
        3'd1:    ea_o = EA_ABS_L;
        3'd2:    ea_o = EA_PC_DISP;
        3'd3:    ea_o = EA_PC_INDEX;
        3'd4:    ea_o = EA_IMM;
        default: ea_o = EA_NONE;  // reserved extended codes
      endcase
    end
  end
endmodule

// File: rtl/addpd_field_decode.sv
module addpd_field_decode
  import addpd_pkg::*;
(
  input  logic [OPC_W-1:0] opcode_i,
  input  sel_e             sel_i,
  input  ea_mode_e         ea_i,
  output dec_t             dec_o
);
  logic is_line_d;
  logic is_addx;
  logic size_bad;

  assign is_line_d = (opcode_i[15:12] == 4'hD);
  assign size_bad  = (opcode_i[7:6] == 2'b11);
  // ADDX pattern beats the generic size decode
  assign is_addx   = opcode_i[8] && (opcode_i[5:4] == 2'b00) && !size_bad;

  always_comb begin
    dec_o = '0;
    if (sel_i == SEL_NBCD || sel_i == SEL_ADDI) begin
      dec_o.op       = (sel_i == SEL_NBCD) ? OP_NBCD : OP_ADDI;
      dec_o.src_mode = EA_NONE;
      dec_o.dst_mode = ea_i;
      dec_o.dst_reg  = opcode_i[2:0];
    end else if (!is_line_d) begin
      dec_o.unhandled = 1'b1;
    end else if (is_addx) begin
      dec_o.op       = OP_ADDX;
      dec_o.size     = size_e'(opcode_i[7:6]);
      dec_o.src_mode = opcode_i[3] ? EA_PREDEC : EA_DN;
      dec_o.dst_mode = opcode_i[3] ? EA_PREDEC : EA_DN;
      dec_o.src_reg  = opcode_i[2:0];
      dec_o.dst_reg  = opcode_i[11:9];
    end else if (size_bad) begin
      dec_o.unhandled = 1'b1;
    end else begin
      dec_o.op   = OP_ADD;
      dec_o.size = size_e'(opcode_i[7:6]);
      if (!opcode_i[8]) begin
        dec_o.src_mode = ea_i;
        dec_o.src_reg  = opcode_i[2:0];
        dec_o.dst_mode = EA_DN;
        dec_o.dst_reg  = opcode_i[11:9];
      end else begin
        dec_o.src_mode = EA_DN;
        dec_o.src_reg  = opcode_i[11:9];
        dec_o.dst_mode = ea_i;
        dec_o.dst_reg  = opcode_i[2:0];
      end
    end
  end
endmodule

// File: rtl/addpd_validator.sv
module addpd_validator
  import addpd_pkg::*;
(
  input  dec_t dec_i,
  output logic illegal_o
);
  function automatic logic dest_bad(ea_mode_e m);
    return (m == EA_IMM) || (m == EA_PC_DISP) || (m == EA_PC_INDEX) || (m == EA_NONE);
  endfunction

  function automatic logic single_bad(ea_mode_e m);
    return dest_bad(m) || (m == EA_AN);
  endfunction

  always_comb begin
    case (dec_i.op)
      OP_ADD:  illegal_o = (dec_i.src_mode == EA_NONE)
                        || (dec_i.src_mode == EA_AN && dec_i.size == SZ_B)
                        || dest_bad(dec_i.dst_mode);
      OP_NBCD,
      OP_ADDI: illegal_o = single_bad(dec_i.dst_mode);
      default: illegal_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/addpd_top.sv
module addpd_top
  import addpd_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 valid_i,
  input  logic [1:0]           sel_i,
  input  logic [OPC_W-1:0]     opcode_i,
  output logic                 valid_o,
  output logic [2:0]           op_o,
  output logic [1:0]           size_o,
  output logic [MODE_W-1:0]    src_mode_o,
  output logic [REG_W-1:0]     src_reg_o,
  output logic [MODE_W-1:0]    dst_mode_o,
  output logic [REG_W-1:0]     dst_reg_o,
  output logic                 illegal_o,
  output logic                 unhandled_o
);
  ea_mode_e ea;
  dec_t     dec;
  logic     illegal;
  dec_t     dec_q;
  logic     illegal_q;
  logic     valid_q;

  addpd_ea_decode u_ea (
    .mode_i (opcode_i[5:3]),
    .reg_i  (opcode_i[2:0]),
    .ea_o   (ea)
  );

  addpd_field_decode u_fields (
    .opcode_i (opcode_i),
    .sel_i    (sel_e'(sel_i)),
    .ea_i     (ea),
    .dec_o    (dec)
  );

  addpd_validator u_val (
    .dec_i     (dec),
    .illegal_o (illegal)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q   <= 1'b0;
      dec_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      valid_q <= valid_i;
      if (valid_i) begin
        dec_q     <= dec;
        illegal_q <= illegal;
      end
    end
  end

  assign valid_o     = valid_q;
  assign op_o        = dec_q.op;
  assign size_o      = dec_q.size;
  assign src_mode_o  = dec_q.src_mode;
  assign src_reg_o   = dec_q.src_reg;
  assign dst_mode_o  = dec_q.dst_mode;
  assign dst_reg_o   = dec_q.dst_reg;
  assign illegal_o   = illegal_q;
  assign unhandled_o = dec_q.unhandled;

  // R2
  latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  // R2
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o && $stable({op_o, size_o, src_mode_o, src_reg_o,
                                      dst_mode_o, dst_reg_o, illegal_o, unhandled_o}));
  // R4
  addx_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && op_o == OP_ADDX |-> src_mode_o == dst_mode_o
      && (src_mode_o == EA_DN || src_mode_o == EA_PREDEC) && !illegal_o);
  // R7
  none_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && dst_mode_o == EA_NONE && op_o != OP_NONE |-> illegal_o);
  // R8
  an_wide_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && op_o == OP_ADD && src_mode_o == EA_AN && size_o != SZ_B
      && dst_mode_o == EA_DN |-> !illegal_o);
  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && unhandled_o |-> !illegal_o && op_o == OP_NONE);
endmodule

// File: tb/addpd_top_bench.sv
module addpd_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid_i = 1'b0;
  logic [1:0]  sel_i = 2'd0;
  logic [15:0] opcode_i = 16'h0;
  logic        valid_o;
  logic [2:0]  op_o;
  logic [1:0]  size_o;
  logic [3:0]  src_mode_o, dst_mode_o;
  logic [2:0]  src_reg_o, dst_reg_o;
  logic        illegal_o, unhandled_o;

  int total = 0;
  int bad = 0;
  logic [20:0] exp_q[$];
  string       tag_q[$];
  logic [20:0] last_exp = '0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  addpd_top u_addpd_top (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .sel_i(sel_i),
    .opcode_i(opcode_i), .valid_o(valid_o), .op_o(op_o), .size_o(size_o),
    .src_mode_o(src_mode_o), .src_reg_o(src_reg_o), .dst_mode_o(dst_mode_o),
    .dst_reg_o(dst_reg_o), .illegal_o(illegal_o), .unhandled_o(unhandled_o)
  );

  function automatic logic [3:0] ea_of(logic [5:0] f);
    if (f[5:3] != 3'd7) return {1'b0, f[5:3]};
    case (f[2:0])
      3'd0: return 4'd7;
      3'd1: return 4'd8;
      3'd2: return 4'd9;
      3'd3: return 4'd10;
      3'd4: return 4'd11;
      default: return 4'd15;
    endcase
  endfunction

  function automatic logic dbad(logic [3:0] m);
    return m == 4'd9 || m == 4'd10 || m == 4'd11 || m == 4'd15;
  endfunction

  // {op,size,src_mode,src_reg,dst_mode,dst_reg,illegal,unhandled}
  function automatic logic [20:0] model(logic [1:0] sel, logic [15:0] w);
    logic [2:0] op = 0; logic [1:0] sz = 0; logic [3:0] sm = 0, dm = 0;
    logic [2:0] sr = 0, dr = 0; logic ill = 0, unh = 0;
    logic [3:0] ea = ea_of(w[5:0]);
    if (sel == 2'd1 || sel == 2'd2) begin           // R11 R12
      op = (sel == 2'd1) ? 3'd3 : 3'd4;
      sm = 4'd15; dm = ea; dr = w[2:0];
      ill = dbad(ea) || ea == 4'd1;
    end else if (w[15:12] != 4'hD) begin            // R10
      unh = 1;
    end else if (w[8] && w[5:4] == 2'b00 && w[7:6] != 2'b11) begin  // R3 R4
      op = 3'd2; sz = w[7:6];
      sm = w[3] ? 4'd4 : 4'd0; dm = sm; sr = w[2:0]; dr = w[11:9];
    end else if (w[7:6] == 2'b11) begin
      unh = 1;
    end else begin                                  // R5 R8 R9
      op = 3'd1; sz = w[7:6];
      if (!w[8]) begin sm = ea; sr = w[2:0]; dm = 0; dr = w[11:9]; end
      else begin sm = 0; sr = w[11:9]; dm = ea; dr = w[2:0]; end
      ill = sm == 4'd15 || (sm == 4'd1 && sz == 2'd0) || dbad(dm);
    end
    return {op, sz, sm, sr, dm, dr, ill, unh};
  endfunction

  function automatic logic [20:0] actual();
    return {op_o, size_o, src_mode_o, src_reg_o, dst_mode_o, dst_reg_o, illegal_o, unhandled_o};
  endfunction

  task automatic drive(logic [1:0] sel, logic [15:0] w, string tag);
    @(negedge clk);
    valid_i = 1'b1; sel_i = sel; opcode_i = w;
    exp_q.push_back(model(sel, w));
    tag_q.push_back(tag);
    last_exp = model(sel, w);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid_i = 1'b0; sel_i = 2'($urandom); opcode_i = 16'($urandom);
    end
  endtask

  task automatic check(string tag, logic [20:0] act, logic [20:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && valid_o) begin
      if (exp_q.size() == 0) begin
        total++; bad++;
        $display("FAIL R2 actual=unexpected result expected=no result");
      end else begin
        check(tag_q.pop_front(), actual(), exp_q.pop_front());
      end
    end
  end

  initial begin
    #1_500_000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", {valid_o, actual()}, 22'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", {valid_o, actual()}, 22'h0);

    // directed
    drive(0, 16'hD549, "R4");  // ADDX.W -(A1),-(A2)
    drive(0, 16'hD781, "R3");  // ADDX.L D1,D3
    drive(0, 16'hD308, "R3");  // ADDX.B -(A0),-(A1)
    drive(0, 16'hD050, "R5");  // ADD.W (A0),D0
    drive(0, 16'hD150, "R5");  // ADD.W D0,(A0)
    drive(0, 16'hD07C, "R6");  // immediate source
    drive(0, 16'hD07A, "R6");  // PC disp source
    drive(0, 16'hD07D, "R7");  // reserved mode-7 code as source
    drive(0, 16'hD17F, "R7");  // reserved code as destination
    drive(0, 16'hD009, "R8");  // byte from An
    drive(0, 16'hD049, "R8");  // word from An
    drive(0, 16'hD17A, "R9");
    drive(0, 16'hD17C, "R9");
    drive(0, 16'hD0C0, "R10");
    drive(0, 16'h5000, "R10");
    drive(1, 16'h0008, "R11");
    drive(1, 16'h0010, "R11");
    drive(2, 16'h003C, "R12");
    drive(2, 16'h0039, "R12");

    // hold after idle cycles
    idle(4);
    check("R2", {valid_o, actual()}, {1'b0, last_exp});
    drive(0, 16'hD3C0, "R10");
    idle(3);
    check("R2", {valid_o, actual()}, {1'b0, last_exp});

    // sweeps
    for (int i = 0; i < 4096; i++) drive(0, 16'hD000 | 16'(i), "R5");
    for (int i = 0; i < 64; i++) begin
      drive(1, 16'($urandom) & 16'hFFC0 | 16'(i), "R11");
      drive(2, 16'($urandom) & 16'hFFC0 | 16'(i), "R12");
    end
    for (int i = 0; i < 16; i++) drive(0, {4'(i % 13), 12'($urandom)}, "R10");
    idle(4);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL R2 actual=%0d pending expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule